// File: doc/BRIEF.md
# I2C Slave Read-Data Transmitter

This block is the transmit half of an I2C slave while the master reads from it. Firmware loads bytes into a small FIFO. An address decoder outside the block tells it that the slave has been selected for a read. The block then shifts each byte onto SDA, most significant bit first, and changes SDA only while SCL is low. After each byte it watches the acknowledge slot. A master acknowledge moves the next byte out. A master not-acknowledge, or a STOP, ends the transfer.

When the master asks for a byte and the FIFO holds none, the slave answers with a not-acknowledge by leaving SDA released. It then keeps SDA released until a STOP, so the master is always free to end the transfer. The block also raises a sticky transmit-empty interrupt. That interrupt is kept fully apart from the SDA path, so it can never hold the bus.

The FIFO can be flushed, it reports full, empty and a sticky overflow, and a slave enable returns the whole interface to its idle, released state. The pad is modelled as a single drive-low enable for SDA.

Top module: `i2c_slv_tx`

## Requirements
- R1: After reset `sda_oe` is 0, `fifo_empty` is 1, and `fifo_full`, `fifo_ovf` and `txe_irq` are 0.
- R2: A byte goes out most significant bit first. For each bit, `sda_oe` is 1 when the bit is 0 and 0 when the bit is 1. `sda_oe` changes only in the clock edge at which SCL is first seen low, and it holds steady while SCL is high.
- R3: Bytes leave in the order they were written. After DEPTH accepted writes `fifo_full` is 1, and after a write `fifo_empty` is 0.
- R4: A write while the FIFO is full is dropped and sets `fifo_ovf`. The flag stays set until `flag_clr` is pulsed or the slave is disabled.
- R5: If a byte is requested while the FIFO is empty (on selection, or after a master acknowledge), the slave drives nothing in that byte. It keeps SDA released until a STOP.
- R6: `txe_irq` sets when a byte removal leaves the FIFO empty, and when an empty read occurs. An accepted write or `flag_clr` clears it, unless a set condition occurs in the same cycle.
- R7: `txe_irq` has no effect on SDA. While the slave is holding the bus released after a not-acknowledge, `sda_oe` stays 0 whatever the interrupt state.
- R8: A `flush` pulse discards all stored bytes (`fifo_empty` 1, `fifo_full` 0). A following read gets no data.
- R9: After a master not-acknowledge, the slave keeps SDA released for further SCL cycles until a STOP.
- R10: A STOP (SDA rising while SCL is high) returns the slave to idle. A later selection starts a fresh byte.
- R11: While `slv_en` is 0 the slave releases SDA, empties the FIFO, clears both flags and ignores writes. Re-enabling restarts from idle.
- R12: During each acknowledge slot, the SCL low phase after the 8th bit, `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slv_en | input | 1 | Slave enable; 0 resets the interface |
| rd_sel | input | 1 | Slave has been addressed for a read |
| scl_in | input | 1 | SCL level (synchronous to clk) |
| sda_in | input | 1 | SDA bus level (synchronous to clk) |
| wr_valid | input | 1 | Firmware byte write strobe |
| wr_data | input | W | Firmware byte |
| flush | input | 1 | Discard FIFO contents |
| flag_clr | input | 1 | Clear interrupt and overflow flags |
| sda_oe | output | 1 | Drive SDA low when 1 |
| txe_irq | output | 1 | Sticky transmit-empty interrupt |
| fifo_empty | output | 1 | FIFO holds no byte |
| fifo_full | output | 1 | FIFO holds DEPTH bytes |
| fifo_ovf | output | 1 | Sticky overflow flag |

## Verification
An SCL fall, a selection with SCL low, a STOP or a disable changes `sda_oe` at the first clock edge that sees it. A write, flush or clear pulse shows on the flags one clock later. The bench holds every SCL phase for four clocks and changes inputs on the falling clock edge. It samples near the end of each phase, several cycles after the edge that caused the result, and it also samples at the end of each high phase to confirm that SDA held steady. Byte values are swept with an arithmetic pattern, and the bit expected at each step is taken from that value.

// File: rtl/i2c_stx_pkg.sv
package i2c_stx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_ACKW = 2'd2,
    ST_HOLD = 2'd3
  } stx_state_e;
endpackage

// File: rtl/i2c_stx_lines.sv
module i2c_stx_lines (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_fall,
  output logic scl_rise,
  output logic stop_seen
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  assign scl_fall  = scl_q & ~scl_in;
  assign scl_rise  = ~scl_q & scl_in;
  assign stop_seen = scl_q & scl_in & ~sda_q & sda_in;
endmodule

// File: rtl/i2c_stx_fifo.sv
module i2c_stx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         flush,
  input  logic         clr,
  input  logic         pop,
  input  logic         nack_evt,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic         ovf,
  output logic         irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);
  localparam logic [CW-1:0] CONE = CW'(1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, irq_set, irq_kill;

  assign full     = (count == CMAX);
  assign empty    = (count == '0);
  assign push_ok  = en & wr_valid & ~flush & ~full;
  assign irq_set  = en & (nack_evt | (pop & (count == CONE) & ~push_ok));
  assign irq_kill = clr | push_ok;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
      end else begin
        if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        if (pop)     rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        if (push_ok && !pop)      count <= count + 1'b1;
        else if (pop && !push_ok) count <= count - 1'b1;
      end
      if (wr_valid && full && !flush) ovf <= 1'b1;
      else if (clr)                   ovf <= 1'b0;
      irq <= irq_set | (irq & ~irq_kill);
    end
  end

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (en && ovf && !clr) |=> ovf);
  a_r6_nack_sets_irq: assert property (@(posedge clk) disable iff (rst)
    (en && nack_evt) |=> irq);
  a_r3_write_fills: assert property (@(posedge clk) disable iff (rst)
    (en && wr_valid && !flush && !pop) |=> !empty);
endmodule

// File: rtl/i2c_stx_fsm.sv
module i2c_stx_fsm
  import i2c_stx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         rd_sel,
  input  logic         scl_in,
  input  logic         sda_in,
  input  logic         scl_fall,
  input  logic         scl_rise,
  input  logic         stop_seen,
  input  logic         fifo_empty,
  input  logic [W-1:0] rd_data,
  output logic         pop,
  output logic         nack_evt,
  output logic         sda_oe
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [BW-1:0] TOPBIT = BW'(W - 1);

  stx_state_e    st, st_n;
  logic [W-1:0]  sh, sh_n;
  logic [BW-1:0] cnt, cnt_n;
  logic          ack, ack_n;

  always_comb begin
    st_n     = st;
    sh_n     = sh;
    cnt_n    = cnt;
    ack_n    = ack;
    pop      = 1'b0;
    nack_evt = 1'b0;
    if (!en || stop_seen) begin
      st_n  = ST_IDLE;
      ack_n = 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (rd_sel && !scl_in) begin
          if (!fifo_empty) begin
            pop   = 1'b1;
            sh_n  = rd_data;
            cnt_n = TOPBIT;
            st_n  = ST_SEND;
          end else begin
            nack_evt = 1'b1;
            st_n     = ST_HOLD;
          end
        end
        ST_SEND: if (scl_fall) begin
          if (cnt == '0) begin
            st_n  = ST_ACKW;
            ack_n = 1'b0;
          end else begin
            sh_n  = sh << 1;
            cnt_n = cnt - 1'b1;
          end
        end
        ST_ACKW: begin
          if (scl_rise) ack_n = ~sda_in;
          if (scl_fall) begin
            if (ack && !fifo_empty) begin
              pop   = 1'b1;
              sh_n  = rd_data;
              cnt_n = TOPBIT;
              st_n  = ST_SEND;
            end else if (ack) begin
              nack_evt = 1'b1;
              st_n     = ST_HOLD;
            end else begin
              st_n = ST_HOLD;
            end
          end
        end
        default: st_n = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      sh     <= '0;
      cnt    <= '0;
      ack    <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      st     <= st_n;
      sh     <= sh_n;
      cnt    <= cnt_n;
      ack    <= ack_n;
      sda_oe <= (st_n == ST_SEND) & ~sh_n[W-1];
    end
  end

  a_r7_hold_released: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD) |-> !sda_oe);
  a_r11_off_released: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sda_oe);
  a_r2_steady_high: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SEND && $past(st) == ST_SEND && scl_in && $past(scl_in)
     && !scl_fall) |=> $stable(sda_oe));
endmodule

// File: rtl/i2c_slv_tx.sv
module i2c_slv_tx #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         slv_en,
  input  logic         rd_sel,
  input  logic         scl_in,
  input  logic         sda_in,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         flush,
  input  logic         flag_clr,
  output logic         sda_oe,
  output logic         txe_irq,
  output logic         fifo_empty,
  output logic         fifo_full,
  output logic         fifo_ovf
);
  logic         scl_fall, scl_rise, stop_seen;
  logic         pop, nack_evt;
  logic [W-1:0] rd_data;

  i2c_stx_lines u_lines (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_fall(scl_fall), .scl_rise(scl_rise), .stop_seen(stop_seen)
  );

  i2c_stx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .en(slv_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .flush(flush), .clr(flag_clr), .pop(pop),
    .nack_evt(nack_evt), .rd_data(rd_data), .empty(fifo_empty),
    .full(fifo_full), .ovf(fifo_ovf), .irq(txe_irq)
  );

  i2c_stx_fsm #(.W(W)) u_fsm (
    .clk(clk), .rst(rst), .en(slv_en), .rd_sel(rd_sel),
    .scl_in(scl_in), .sda_in(sda_in), .scl_fall(scl_fall),
    .scl_rise(scl_rise), .stop_seen(stop_seen), .fifo_empty(fifo_empty),
    .rd_data(rd_data), .pop(pop), .nack_evt(nack_evt), .sda_oe(sda_oe)
  );
endmodule

// File: tb/i2c_slv_tx_tb.sv
module i2c_slv_tx_tb;
  localparam int CLK_P = 10;
  localparam int W = 8;
  localparam int DEPTH = 2;

  logic clk = 1'b0, rst = 1'b1, slv_en = 1'b1, rd_sel = 1'b0;
  logic scl = 1'b1, m_low = 1'b0;
  logic wr_valid = 1'b0, flush = 1'b0, flag_clr = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic sda_oe, txe_irq, fifo_empty, fifo_full, fifo_ovf, sda_line;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;
  assign sda_line = ~(sda_oe | m_low);

  i2c_slv_tx #(.W(W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .slv_en(slv_en), .rd_sel(rd_sel),
    .scl_in(scl), .sda_in(sda_line), .wr_valid(wr_valid),
    .wr_data(wr_data), .flush(flush), .flag_clr(flag_clr),
    .sda_oe(sda_oe), .txe_irq(txe_irq), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .fifo_ovf(fifo_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] b);
    wr_valid = 1'b1; wr_data = b; tick(1); wr_valid = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
  endtask

  task automatic start_rd();
    m_low = 1'b1; tick(2); scl = 1'b0; tick(2); m_low = 1'b0; rd_sel = 1'b1;
  endtask

  task automatic stop_bus();
    rd_sel = 1'b0; m_low = 1'b1; tick(2); scl = 1'b1; tick(2); m_low = 1'b0; tick(3);
  endtask

  // one byte slot; valid=0 means the slave must leave SDA released
  task automatic rd_byte(input logic [W-1:0] b, input bit valid, input bit mack, input string req);
    for (int i = W-1; i >= 0; i--) begin
      tick(3);
      chk(req, 32'(sda_oe), valid ? 32'(!b[i]) : 32'd0);
      scl = 1'b1; tick(4);
      chk("R2 steady", 32'(sda_oe), valid ? 32'(!b[i]) : 32'd0);
      scl = 1'b0;
    end
    tick(3);
    chk("R12 ack slot", 32'(sda_oe), 32'd0);
    m_low = mack; scl = 1'b1; tick(4); scl = 1'b0; tick(1); m_low = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3); rst = 1'b0; tick(1);
    chk("R1 sda_oe", 32'(sda_oe), 0);
    chk("R1 empty", 32'(fifo_empty), 1);
    chk("R1 full", 32'(fifo_full), 0);
    chk("R1 ovf", 32'(fifo_ovf), 0);
    chk("R1 irq", 32'(txe_irq), 0);

    // sweep of byte pairs: order, MSB-first, master NACK hold (R2 R3 R6 R9)
    for (int v = 0; v < 16; v++) begin
      logic [W-1:0] a, b;
      a = W'((v * 37 + 5) % 256);
      b = W'((v * 91 + 200) % 256);
      push(a);
      chk("R3 not empty", 32'(fifo_empty), 0);
      push(b);
      chk("R3 full", 32'(fifo_full), 1);
      start_rd();
      rd_byte(a, 1'b1, 1'b1, "R2 bit");
      rd_byte(b, 1'b1, 1'b0, "R3 order");
      chk("R6 irq on drain", 32'(txe_irq), 1);
      scl = 1'b1; tick(4);
      chk("R9 hold high", 32'(sda_oe), 0);
      scl = 1'b0; tick(4);
      chk("R9 hold low", 32'(sda_oe), 0);
      stop_bus();
      pulse_clr();
      chk("R6 clr", 32'(txe_irq), 0);
      chk("R3 empty", 32'(fifo_empty), 1);
    end

    // empty read on selection (R5 R6 R7), write clears irq, restart after STOP (R10)
    start_rd();
    rd_byte('0, 1'b0, 1'b0, "R5 empty read");
    chk("R6 irq on empty read", 32'(txe_irq), 1);
    rd_byte('0, 1'b0, 1'b1, "R7 irq not holding");
    stop_bus();
    push(8'hA5);
    chk("R6 write clears", 32'(txe_irq), 0);
    start_rd();
    rd_byte(8'hA5, 1'b1, 1'b1, "R10 fresh byte");
    rd_byte('0, 1'b0, 1'b0, "R5 empty after ack");
    chk("R6 irq after ack empty", 32'(txe_irq), 1);
    stop_bus();
    pulse_clr();

    // overflow (R4)
    push(8'h11); push(8'h22); push(8'h33);
    chk("R4 ovf", 32'(fifo_ovf), 1);
    chk("R4 full", 32'(fifo_full), 1);
    start_rd();
    rd_byte(8'h11, 1'b1, 1'b1, "R4 first");
    rd_byte(8'h22, 1'b1, 1'b1, "R4 second");
    rd_byte('0, 1'b0, 1'b0, "R4 dropped byte");
    chk("R4 ovf sticky", 32'(fifo_ovf), 1);
    stop_bus();
    pulse_clr();
    chk("R4 ovf cleared", 32'(fifo_ovf), 0);

    // flush (R8)
    push(8'h44); push(8'h55);
    flush = 1'b1; tick(1); flush = 1'b0;
    chk("R8 empty", 32'(fifo_empty), 1);
    chk("R8 full", 32'(fifo_full), 0);
    start_rd();
    rd_byte('0, 1'b0, 1'b0, "R8 no data");
    stop_bus();
    pulse_clr();

    // disable mid-byte (R11)
    push(8'h00);
    start_rd();
    tick(3);
    chk("R2 first bit low", 32'(sda_oe), 1);
    scl = 1'b1; tick(4); scl = 1'b0; tick(2);
    slv_en = 1'b0; tick(1);
    chk("R11 released", 32'(sda_oe), 0);
    push(8'h77);
    chk("R11 write ignored", 32'(fifo_empty), 1);
    chk("R11 irq cleared", 32'(txe_irq), 0);
    slv_en = 1'b1;
    rd_byte('0, 1'b0, 1'b0, "R11 restart empty");
    stop_bus();
    pulse_clr();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule